// File: doc/BRIEF.md
# UTOPIA Level 2 Receive PHY Port

This block is the physical-layer side of a UTOPIA Level 2 receive link. A local producer writes ATM cells one byte per clock, and each cell is 53 bytes long. The block keeps only whole cells in a small cell FIFO. An ATM-layer master polls the block over a 5-bit address. It reads cells out over an 8-bit bus, using an active-low enable and a start-of-cell marker.

The block answers only to its own configured port address. The cell-available answer is registered, so it appears one clock after the address that polled it. At the end of every cell the block inserts one idle clock and drops cell-available for that clock. This gives the read pointer time to move to the next cell.

A cell that arrives while all slots are full is discarded whole. The discard sets a sticky overflow flag, which stays set until a clear input resets it.

The bus outputs are not driven as tristates inside the block. Each bus output comes with an enable output that the pad ring uses to drive it.

Top module: `utopia_rx_port`

## Requirements
- R1: `rxClavOe` is high in the cycle after `rxAddr` equals the usable port address, and low in the cycle after any other address.
- R2: While `rxClavOe` is high, `rxClav` is high exactly when at least one complete cell remains that has not been fully read. Outside the gap cycle of R5 it is low when the FIFO is empty, and it is never high while `rxClavOe` is low.
- R3: The port is selected by a clock edge at which `rxEnbN` is high and the address matches. A byte is driven on the cycle after a clock edge that samples `rxEnbN` low on a selected port. A port that is not selected, or that holds no cell, drives nothing and consumes nothing.
- R4: `rxSoc` is high only together with the first byte of a cell. Bytes leave in the order they were written.
- R5: In the clock after the last byte of a cell, no byte is driven and `rxClav` is low. The next cell's first byte therefore comes two clocks after that last byte at the earliest.
- R6: If `rxEnbN` goes high in the middle of a cell, output pauses. When the enable returns, the transfer resumes with the next byte, and the cell is released only after all 53 bytes have gone out.
- R7: A cell whose first byte arrives while all cell slots are occupied is dropped completely and sets `ovfFlag`. The flag stays high until `ovfClear` is pulsed.
- R8: In direct-status mode (`cfgDirect` = 1), a port address with bit 2 set is unusable and never answers a poll. In normal mode any of the 32 addresses is usable.
- R9: After reset, neither output enable is asserted, the FIFO is empty and `ovfFlag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UTOPIA receive clock, shared with the writer |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPortAddr | input | 5 | Port address of this PHY |
| cfgDirect | input | 1 | Direct-status mode, restricts usable addresses |
| wrValid | input | 1 | Writer byte strobe |
| wrData | input | 8 | Writer byte; 53 consecutive strobes form one cell |
| ovfClear | input | 1 | Clears the overflow flag |
| ovfFlag | output | 1 | Sticky flag set when a cell is dropped |
| rxAddr | input | 5 | Poll/select address from the ATM layer, bit 4 MSB |
| rxEnbN | input | 1 | Active-low read enable |
| rxData | output | 8 | Cell byte, bit 7 MSB, zero when not driven |
| rxDataOe | output | 1 | Pad enable for `rxData` and `rxSoc` |
| rxSoc | output | 1 | Start-of-cell marker |
| rxClav | output | 1 | Cell-available answer to a poll |
| rxClavOe | output | 1 | Pad enable for `rxClav` |

## Verification
The bench uses the default sizes: 53-byte cells and four cell slots. With only four slots, five consecutive writes are enough to reach the overflow path. Drains of two and four cells read with the enable held low throughout, which makes the one-clock gap and the start-of-cell position observable at every cell boundary. The port address 13 has bit 2 set, so in direct-status mode it lands on an unusable address, while 9 stays usable. Randomly chosen addresses are polled against both matching and non-matching ports.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

  // Strobes issued by the control unit to the cell store.
  typedef struct packed {
    logic wrStore;    // write current byte into the slot being filled
    logic wrCommit;   // last byte written: cell becomes visible
    logic rdLoad;     // load output byte register from the read slot
    logic rdRelease;  // last byte loaded: read slot is freed
  } rxStrobes_t;

  // Address bit that must be clear in direct-status mode.
  localparam int DIRECT_BLOCK_BIT = 2;

endpackage

// File: rtl/utopia_rx_datapath.sv
module utopia_rx_datapath
  import utopia_rx_pkg::*;
#(
  parameter int CELL_BYTES  = 53,
  parameter int DEPTH_CELLS = 4,
  parameter int DATA_W      = 8,
  localparam int IDX_W      = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] outByte,
  output logic              cellsAvail,
  output logic              fifoFull
);

  localparam int MEM_DEPTH = CELL_BYTES * DEPTH_CELLS;
  localparam int MADDR_W   = $clog2(MEM_DEPTH);
  localparam int PTR_W     = (DEPTH_CELLS > 1) ? $clog2(DEPTH_CELLS) : 1;
  localparam int CNT_W     = $clog2(DEPTH_CELLS + 1);

  logic [DATA_W-1:0]  cellMem [MEM_DEPTH];
  logic [PTR_W-1:0]   wrCell, rdCell;
  logic [CNT_W-1:0]   cellCount;
  logic [MADDR_W-1:0] wrAddr, rdAddr;

  assign wrAddr = MADDR_W'(wrCell) * MADDR_W'(CELL_BYTES) + MADDR_W'(wrIdx);
  assign rdAddr = MADDR_W'(rdCell) * MADDR_W'(CELL_BYTES) + MADDR_W'(rdIdx);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH_CELLS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.wrStore) cellMem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCell    <= '0;
      rdCell    <= '0;
      cellCount <= '0;
      outByte   <= '0;
    end else begin
      if (strb.wrCommit)  wrCell <= nextPtr(wrCell);
      if (strb.rdRelease) rdCell <= nextPtr(rdCell);
      if (strb.rdLoad)    outByte <= cellMem[rdAddr];
      case ({strb.wrCommit, strb.rdRelease})
        2'b10:   cellCount <= cellCount + 1'b1;
        2'b01:   cellCount <= cellCount - 1'b1;
        default: cellCount <= cellCount;
      endcase
    end
  end

  assign cellsAvail = (cellCount != '0);
  assign fifoFull   = (cellCount == CNT_W'(DEPTH_CELLS));

endmodule

// File: rtl/utopia_rx_ctrl.sv
module utopia_rx_ctrl
  import utopia_rx_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int ADDR_W     = 5,
  localparam int IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgPortAddr,
  input  logic              cfgDirect,
  input  logic              wrValid,
  input  logic              ovfClear,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic              rxEnbN,
  input  logic              cellsAvail,
  input  logic              fifoFull,
  output rxStrobes_t        strb,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              ovfFlag,
  output logic              rxDataOe,
  output logic              rxSoc,
  output logic              rxClav,
  output logic              rxClavOe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic addrOk, selected, clavOeQ, dataOeQ, socQ, lastOutQ, gapQ;
  logic dropQ, ovfQ;
  logic rdGo, rdLast, wrFirst, wrLast, wrDrop;

  // Address decode with the direct-status restriction.
  assign addrOk = (rxAddr == cfgPortAddr) &&
                  !(cfgDirect && cfgPortAddr[DIRECT_BLOCK_BIT]);

  // Read side: one byte per enabled cycle, never in the cycle after a last byte.
  assign rdLast = (rdIdx == LAST_IDX);
  assign rdGo   = !rxEnbN && selected && !lastOutQ && cellsAvail;

  // Write side: full check is taken on the first byte and held for the cell.
  assign wrFirst = (wrIdx == '0);
  assign wrLast  = (wrIdx == LAST_IDX);
  assign wrDrop  = wrFirst ? fifoFull : dropQ;

  always_comb begin
    strb           = '0;
    strb.rdLoad    = rdGo;
    strb.rdRelease = rdGo && rdLast;
    strb.wrStore   = wrValid && !wrDrop;
    strb.wrCommit  = wrValid && !wrDrop && wrLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selected <= 1'b0;
      clavOeQ  <= 1'b0;
      dataOeQ  <= 1'b0;
      socQ     <= 1'b0;
      lastOutQ <= 1'b0;
      gapQ     <= 1'b0;
      rdIdx    <= '0;
    end else begin
      clavOeQ  <= addrOk;
      if (rxEnbN) selected <= addrOk;
      dataOeQ  <= rdGo;
      socQ     <= rdGo && (rdIdx == '0);
      lastOutQ <= rdGo && rdLast;
      gapQ     <= lastOutQ;
      if (rdGo) rdIdx <= rdLast ? '0 : rdIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      dropQ <= 1'b0;
      ovfQ  <= 1'b0;
    end else begin
      if (wrValid) begin
        wrIdx <= wrLast ? '0 : wrIdx + 1'b1;
        if (wrFirst) dropQ <= fifoFull;
      end
      if (wrValid && wrFirst && fifoFull) ovfQ <= 1'b1;
      else if (ovfClear)                  ovfQ <= 1'b0;
    end
  end

  assign ovfFlag  = ovfQ;
  assign rxDataOe = dataOeQ;
  assign rxSoc    = socQ;
  assign rxClavOe = clavOeQ;
  assign rxClav   = clavOeQ && cellsAvail && !gapQ;

endmodule

// File: rtl/utopia_rx_port.sv
module utopia_rx_port
  import utopia_rx_pkg::*;
#(
  parameter int CELL_BYTES  = 53,
  parameter int DEPTH_CELLS = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgPortAddr,
  input  logic              cfgDirect,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ovfClear,
  output logic              ovfFlag,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic              rxEnbN,
  output logic [DATA_W-1:0] rxData,
  output logic              rxDataOe,
  output logic              rxSoc,
  output logic              rxClav,
  output logic              rxClavOe
);

  localparam int IDX_W = $clog2(CELL_BYTES);

  rxStrobes_t        strb;
  logic [IDX_W-1:0]  wrIdx, rdIdx;
  logic [DATA_W-1:0] outByte;
  logic              cellsAvail, fifoFull;

  utopia_rx_ctrl #(
    .CELL_BYTES(CELL_BYTES),
    .ADDR_W    (ADDR_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgPortAddr(cfgPortAddr),
    .cfgDirect  (cfgDirect),
    .wrValid    (wrValid),
    .ovfClear   (ovfClear),
    .rxAddr     (rxAddr),
    .rxEnbN     (rxEnbN),
    .cellsAvail (cellsAvail),
    .fifoFull   (fifoFull),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .rdIdx      (rdIdx),
    .ovfFlag    (ovfFlag),
    .rxDataOe   (rxDataOe),
    .rxSoc      (rxSoc),
    .rxClav     (rxClav),
    .rxClavOe   (rxClavOe)
  );

  utopia_rx_datapath #(
    .CELL_BYTES (CELL_BYTES),
    .DEPTH_CELLS(DEPTH_CELLS),
    .DATA_W     (DATA_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .wrData    (wrData),
    .outByte   (outByte),
    .cellsAvail(cellsAvail),
    .fifoFull  (fifoFull)
  );

  assign rxData = rxDataOe ? outByte : '0;

endmodule

// File: rtl/utopia_rx_checker.sv
module utopia_rx_checker #(
  parameter int CELL_BYTES = 53,
  parameter int ADDR_W     = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cfgPortAddr,
  input logic              cfgDirect,
  input logic [ADDR_W-1:0] rxAddr,
  input logic              rxEnbN,
  input logic              rxDataOe,
  input logic              rxSoc,
  input logic              rxClav,
  input logic              rxClavOe,
  input logic              ovfFlag,
  input logic              ovfClear
);

  localparam int CNT_W = $clog2(CELL_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;
  logic             polled;

  assign polled = (rxAddr == cfgPortAddr) && !(cfgDirect && cfgPortAddr[2]);

  always_ff @(posedge clk) begin
    if (!rstN) byteCnt <= '0;
    else if (rxDataOe) byteCnt <= (byteCnt == LAST) ? '0 : byteCnt + 1'b1;
  end

  a_r1_answer_match: assert property (@(posedge clk) disable iff (!rstN)
    polled |=> rxClavOe);
  a_r1_quiet_other: assert property (@(posedge clk) disable iff (!rstN)
    !polled |=> !rxClavOe);
  a_r2_clav_needs_oe: assert property (@(posedge clk) disable iff (!rstN)
    rxClav |-> rxClavOe);
  a_r3_data_after_enable: assert property (@(posedge clk) disable iff (!rstN)
    rxDataOe |-> $past(!rxEnbN));
  a_r4_soc_only_first: assert property (@(posedge clk) disable iff (!rstN)
    rxSoc |-> (rxDataOe && byteCnt == '0));
  a_r4_first_has_soc: assert property (@(posedge clk) disable iff (!rstN)
    (rxDataOe && byteCnt == '0) |-> rxSoc);
  a_r5_gap_after_cell: assert property (@(posedge clk) disable iff (!rstN)
    (rxDataOe && byteCnt == LAST) |=> (!rxDataOe && !rxClav));
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClear) |=> ovfFlag);

endmodule

bind utopia_rx_port utopia_rx_checker #(
  .CELL_BYTES(CELL_BYTES),
  .ADDR_W    (ADDR_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgPortAddr(cfgPortAddr),
  .cfgDirect  (cfgDirect),
  .rxAddr     (rxAddr),
  .rxEnbN     (rxEnbN),
  .rxDataOe   (rxDataOe),
  .rxSoc      (rxSoc),
  .rxClav     (rxClav),
  .rxClavOe   (rxClavOe),
  .ovfFlag    (ovfFlag),
  .ovfClear   (ovfClear)
);

// File: tb/tb_utopia_rx_port.sv
module tb_utopia_rx_port;

  localparam int CB = 53;
  localparam int DC = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] cfgPortAddr;
  logic       cfgDirect;
  logic       wrValid;
  logic [7:0] wrData;
  logic       ovfClear;
  logic       ovfFlag;
  logic [4:0] rxAddr;
  logic       rxEnbN;
  logic [7:0] rxData;
  logic       rxDataOe, rxSoc, rxClav, rxClavOe;

  always #5 clk = ~clk;

  utopia_rx_port dut (
    .clk(clk), .rstN(rstN), .cfgPortAddr(cfgPortAddr), .cfgDirect(cfgDirect),
    .wrValid(wrValid), .wrData(wrData), .ovfClear(ovfClear), .ovfFlag(ovfFlag),
    .rxAddr(rxAddr), .rxEnbN(rxEnbN), .rxData(rxData), .rxDataOe(rxDataOe),
    .rxSoc(rxSoc), .rxClav(rxClav), .rxClavOe(rxClavOe)
  );

  int errors = 0;
  int checks = 0;
  int unsigned cellBase [64];
  int q[$];
  int nextId = 0;

  function automatic logic [7:0] cellByte(int id, int i);
    return 8'(cellBase[id % 64] + i * 7 + id * 3);
  endfunction

  function automatic bit usable(logic [4:0] a);
    return (a == cfgPortAddr) && !(cfgDirect && cfgPortAddr[2]);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Producer writes one cell; the model keeps it only if a slot is free.
  task automatic writeCell();
    int id;
    id = nextId++;
    if (q.size() < DC) q.push_back(id);
    for (int i = 0; i < CB; i++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrData  = cellByte(id, i);
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic poll(logic [4:0] a);
    @(negedge clk);
    rxAddr = a;
    rxEnbN = 1'b1;
    @(negedge clk);
    check("R1", "clav output enable", int'(rxClavOe), int'(usable(a)));
    check("R2", "clav value", int'(rxClav), int'(usable(a) && q.size() != 0));
  endtask

  // Reads n cells with enable held low, optionally pausing after byte pauseAt.
  task automatic readCells(int n, int pauseAt);
    @(negedge clk);
    rxAddr = cfgPortAddr;
    rxEnbN = 1'b1;
    @(negedge clk);
    rxEnbN = 1'b0;
    for (int c = 0; c < n; c++) begin
      int id, bad, socBad;
      id = q.pop_front();
      bad = 0;
      socBad = 0;
      for (int i = 0; i < CB; i++) begin
        @(negedge clk);
        if (!rxDataOe || rxData != cellByte(id, i)) bad++;
        if (rxSoc != (i == 0)) socBad++;
        if (i == pauseAt) begin
          rxEnbN = 1'b1;
          @(negedge clk);
          check("R6", "no data in pause cycle 1", int'(rxDataOe), 0);
          @(negedge clk);
          check("R6", "no data in pause cycle 2", int'(rxDataOe), 0);
          rxEnbN = 1'b0;
        end
      end
      check("R4", "byte order mismatches", bad, 0);
      check("R4", "start-of-cell misplacements", socBad, 0);
      @(negedge clk);
      check("R5", "idle after last byte", int'(rxDataOe), 0);
      check("R5", "clav low after last byte", int'(rxClav), 0);
      if (c == n - 1) rxEnbN = 1'b1;
    end
    @(negedge clk);
    check("R2", "clav after drain", int'(rxClav), int'(q.size() != 0));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) cellBase[i] = $urandom;
    rstN = 1'b0; cfgPortAddr = 5'd6; cfgDirect = 1'b0;
    wrValid = 1'b0; wrData = '0; ovfClear = 1'b0;
    rxAddr = 5'd0; rxEnbN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "data enable after reset", int'(rxDataOe), 0);
    check("R9", "clav enable after reset", int'(rxClavOe), 0);
    check("R9", "overflow flag after reset", int'(ovfFlag), 0);

    poll(5'd6);                       // empty FIFO, own address
    writeCell(); writeCell();
    poll(5'd6);
    poll(5'd7);
    poll(5'd22);
    readCells(2, -1);                 // back-to-back pair

    // R3: enable while another port is selected, and on an empty port.
    writeCell();
    @(negedge clk); rxAddr = 5'd7; rxEnbN = 1'b1;
    @(negedge clk); rxEnbN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3", "no data when not selected", int'(rxDataOe), 0);
    end
    rxEnbN = 1'b1;
    readCells(1, -1);                 // cell must still start at byte 0
    @(negedge clk); rxAddr = cfgPortAddr; rxEnbN = 1'b1;
    @(negedge clk); rxEnbN = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3", "no data from empty port", int'(rxDataOe), 0);
    end
    rxEnbN = 1'b1;

    // R6: pause in the middle of a cell.
    writeCell(); writeCell();
    readCells(2, 20);

    // R7: five cells into four slots.
    for (int k = 0; k < 5; k++) writeCell();
    check("R7", "overflow flag set", int'(ovfFlag), 1);
    repeat (5) @(negedge clk);
    check("R7", "overflow flag holds", int'(ovfFlag), 1);
    ovfClear = 1'b1;
    @(negedge clk);
    ovfClear = 1'b0;
    check("R7", "overflow flag cleared", int'(ovfFlag), 0);
    readCells(4, -1);
    poll(cfgPortAddr);                // dropped cell must not appear

    // R8: direct-status address restriction.
    cfgDirect = 1'b1; cfgPortAddr = 5'd13;
    writeCell();
    @(negedge clk); rxAddr = 5'd13;
    @(negedge clk);
    check("R8", "blocked address silent", int'(rxClavOe), 0);
    cfgPortAddr = 5'd9;
    poll(5'd9);
    check("R8", "usable address answers", int'(rxClavOe), 1);
    readCells(1, -1);
    cfgDirect = 1'b0; cfgPortAddr = 5'd13;
    writeCell();
    poll(5'd13);
    check("R8", "normal mode accepts bit 2", int'(rxClavOe), 1);
    readCells(1, -1);

    // Random polls over random port addresses.
    writeCell();
    for (int k = 0; k < 24; k++) begin
      logic [4:0] a;
      if (k % 8 == 0) cfgPortAddr = 5'($urandom);
      a = ($urandom % 4 == 0) ? cfgPortAddr : 5'($urandom);
      poll(a);
    end
    readCells(1, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule